// File: doc/BRIEF.md
# Shared Converter Access Arbiter

A single analog-to-digital converter is used by three clients: a low-power sequencer (index 0), a scanning digital controller (index 1) and a radio power-detect controller (index 2). Each client asks for one conversion with a one-cycle start strobe. The arbiter decides which client drives the converter, starts it and runs a fixed-latency conversion. Every client gets a result word for every start strobe it raises, unless the strobe is ignored as listed below. The flag bits of the word tell the client whether its data can be used.

There are three decision modes. In fixed mode the higher priority wins. A higher-priority client can also take the converter away from a conversion that is already running. Rotating mode serves the waiting clients in turn. Forced mode skips arbitration and serves only one selected client. A programmable settle gap follows each completed conversion before the next decision is made. The converter itself is modelled as a counter with `CONV_LAT` cycles of latency. It captures `sample_in` on the cycle it finishes.

Top module: `adc_share_arbiter`

## Requirements
- R1: After reset `grant`, `conv_start` and `res_done` are zero, all result words are zero, and the priorities are radio 2, low-power 1, digital 0.
- R2: A priority write (`prio_wr`) takes effect only when the three values are mutually distinct and each is at most 2. Any other write leaves the previous priorities in force.
- R3: In fixed mode (`mode`=0), the idle arbiter grants the waiting or newly requesting client with the highest priority. The losers stay waiting until they are served.
- R4: In rotating mode (`mode`=1), the search starts at the client after the one granted last, in the order 0,1,2,0. Two clients that request continuously are therefore granted alternately.
- R5: In forced mode (`mode`=2), only the client numbered `force_sel` can be granted. A start strobe from any other client is answered in the next cycle with `res_done` and flag 1.
- R6: In fixed mode, a start strobe whose priority is above that of the busy owner preempts the owner. In the next cycle the old owner receives `res_done` with flag 2 and data 0. In the same cycle the newcomer holds `grant` and `conv_start` pulses.
- R7: A start strobe that arrives while another client owns the converter and cannot preempt it is answered in the next cycle with flag 1 and data 0. A repeated strobe from the owner itself is ignored.
- R8: A conversion that is not preempted ends `CONV_LAT` cycles after its grant. The owner then receives `res_done`, flag 0, and the value of `sample_in` at that moment as its data.
- R9: After a completed conversion the arbiter waits `settle_cyc` cycles (values above 4 count as 4) before the decision cycle. The next `conv_start` is therefore seen `settle_cyc`+1 cycles after the `res_done`.
- R10: A result word holds the data in bits 12:0 and the flag in bits 14:13. Flag codes are 0 for valid, 1 for not granted and 2 for interrupted. A word never carries code 3, and it holds its value until the next `res_done` for that client.
- R11: `grant` is one-hot or zero. `conv_start` pulses for one cycle exactly when a conversion begins, and the granted client is shown alongside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start | input | 3 | One-cycle start strobes, bit 0 low-power, bit 1 digital, bit 2 radio |
| mode | input | 2 | 0 fixed, 1 rotating, 2 forced |
| force_sel | input | 2 | Client served in forced mode |
| prio_wr | input | 1 | Priority write strobe |
| prio_lp | input | 2 | New priority, low-power client |
| prio_dg | input | 2 | New priority, digital client |
| prio_rf | input | 2 | New priority, radio client |
| settle_cyc | input | 3 | Settle gap after completion, 0 to 4 |
| sample_in | input | DATA_W | Converter output value |
| grant | output | 3 | Current owner, one-hot |
| conv_start | output | 1 | Converter start pulse |
| res_done | output | 3 | Result word update strobes |
| res_lp | output | DATA_W+2 | Result word, low-power client |
| res_dg | output | DATA_W+2 | Result word, digital client |
| res_rf | output | DATA_W+2 | Result word, radio client |

## Verification
The bench goes after preemption in the very cycle a lower-priority conversion would otherwise run on. A design that gets this wrong drops the old owner's flag-2 word, or leaves stale data in that word. It also checks a strobe that cannot preempt: a wrong design would queue it silently or answer it with flag 2 instead of 1. Rotation with two clients that never stop requesting exposes a pointer that does not skip the client just served, which would starve the other client. The settle gap is measured at its limit and beyond it, including out-of-range counts and priority writes with duplicate values, which a wrong design would accept.

// File: rtl/adc_arb_pkg.sv
// Shared constants and helpers for the converter access arbiter.
// Assumes exactly three clients: 0 low-power, 1 digital, 2 radio.
package adc_arb_pkg;
    localparam int NREQ   = 3;
    localparam int IDX_W  = 2;
    localparam int FLAG_W = 2;

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [1:0]       prio_t;

    localparam logic [1:0] MODE_FIXED = 2'd0;
    localparam logic [1:0] MODE_LOOP  = 2'd1;
    localparam logic [1:0] MODE_FORCE = 2'd2;

    localparam logic [FLAG_W-1:0] FLG_OK      = 2'd0;
    localparam logic [FLAG_W-1:0] FLG_NOGRANT = 2'd1;
    localparam logic [FLAG_W-1:0] FLG_PREEMPT = 2'd2;

    localparam prio_t PRIO_RST_LP = 2'd1;
    localparam prio_t PRIO_RST_DG = 2'd0;
    localparam prio_t PRIO_RST_RF = 2'd2;

    typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_SETTLE} arb_state_e;

    // Mode 3 is treated as fixed priority.
    function automatic logic mode_is_fixed(input logic [1:0] m);
        return (m != MODE_LOOP) && (m != MODE_FORCE);
    endfunction

    // Client that follows i in the rotation order.
    function automatic idx_t next_idx(input idx_t i);
        return (int'(i) == NREQ-1) ? idx_t'(0) : idx_t'(int'(i) + 1);
    endfunction
endpackage

// File: rtl/adc_arb_prio.sv
// Priority register bank for the three clients.
// Assumes writes are one-cycle strobes; a write is taken only when the
// three values are distinct and each is at most NREQ-1.
module adc_arb_prio
    import adc_arb_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr,
    input  prio_t                  in_lp,
    input  prio_t                  in_dg,
    input  prio_t                  in_rf,
    output logic [NREQ-1:0][1:0]   prio_q
);
    logic wr_ok;

    // Validity of a requested write: distinct and in range.
    always_comb begin
        wr_ok = (in_lp != in_dg) && (in_lp != in_rf) && (in_dg != in_rf) &&
                (int'(in_lp) < NREQ) && (int'(in_dg) < NREQ) && (int'(in_rf) < NREQ);
    end

    // Priority storage with reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q[0] <= PRIO_RST_LP;
            prio_q[1] <= PRIO_RST_DG;
            prio_q[2] <= PRIO_RST_RF;
        end else if (wr && wr_ok) begin
            prio_q[0] <= in_lp;
            prio_q[1] <= in_dg;
            prio_q[2] <= in_rf;
        end
    end

    AST_PRIO_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_q[0] != prio_q[1]) && (prio_q[0] != prio_q[2]) && (prio_q[1] != prio_q[2]) &&
        (int'(prio_q[0]) < NREQ) && (int'(prio_q[1]) < NREQ) && (int'(prio_q[2]) < NREQ)); // R2
endmodule

// File: rtl/adc_arb_pick.sv
// Combinational winner selection among candidate clients.
// Assumes priorities are distinct; mode picks fixed, rotating or forced rule.
module adc_arb_pick
    import adc_arb_pkg::*;
(
    input  logic [NREQ-1:0]        cand,
    input  logic [1:0]             mode,
    input  logic [NREQ-1:0][1:0]   prio,
    input  idx_t                   ptr,
    input  idx_t                   force_sel,
    output logic                   hit,
    output idx_t                   idx
);
    // Select one candidate according to the active rule.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        if (mode == MODE_FORCE) begin
            if (int'(force_sel) < NREQ) begin
                if (cand[force_sel]) begin
                    hit = 1'b1;
                    idx = force_sel;
                end
            end
        end else if (mode == MODE_LOOP) begin
            for (int k = 0; k < NREQ; k++) begin
                if (!hit && cand[(int'(ptr) + k) % NREQ]) begin
                    hit = 1'b1;
                    idx = idx_t'((int'(ptr) + k) % NREQ);
                end
            end
        end else begin
            for (int i = 0; i < NREQ; i++) begin
                if (cand[i] && (!hit || (prio[i] > prio[idx]))) begin
                    hit = 1'b1;
                    idx = idx_t'(i);
                end
            end
        end
    end
endmodule

// File: rtl/adc_conv_stub.sv
// Fixed-latency stand-in for the analog converter.
// Assumes LAT >= 1; a start while running restarts the count.
module adc_conv_stub #(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic fin
);
    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

    logic          run_q;
    logic [CW-1:0] cnt_q;

    // Conversion timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            cnt_q <= CW'(LAT-1);
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    // Finish indication on the last cycle of the count.
    assign fin = run_q && (cnt_q == '0);

    AST_STUB_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && (cnt_q != '0)) |=> run_q); // R8
endmodule

// File: rtl/adc_share_arbiter.sv
// Access arbiter for one converter shared by three clients.
// Assumes one-cycle start strobes; tags every answered strobe with a flag
// (0 valid, 1 not granted, 2 interrupted) above DATA_W data bits.
module adc_share_arbiter
    import adc_arb_pkg::*;
#(
    parameter int DATA_W     = 13,
    parameter int CONV_LAT   = 4,
    parameter int SETTLE_MAX = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           req_start,
    input  logic [1:0]           mode,
    input  logic [1:0]           force_sel,
    input  logic                 prio_wr,
    input  logic [1:0]           prio_lp,
    input  logic [1:0]           prio_dg,
    input  logic [1:0]           prio_rf,
    input  logic [2:0]           settle_cyc,
    input  logic [DATA_W-1:0]    sample_in,
    output logic [2:0]           grant,
    output logic                 conv_start,
    output logic [2:0]           res_done,
    output logic [DATA_W+1:0]    res_lp,
    output logic [DATA_W+1:0]    res_dg,
    output logic [DATA_W+1:0]    res_rf
);
    localparam int WORD_W = DATA_W + FLAG_W;

    arb_state_e            state_q;
    idx_t                  owner_q, ptr_q;
    logic [2:0]            scnt_q, settle_eff;
    logic [NREQ-1:0]       pend_q, pend_n;
    logic                  cs_q;
    logic [NREQ-1:0]       done_q;
    logic [WORD_W-1:0]     word_q [NREQ];

    logic [NREQ-1:0][1:0]  prio;
    logic [NREQ-1:0]       frc_rej, busy_rej, rej, arr, beat, cand_idle, sel_mask;
    logic                  busy, idle_hit, pre_hit, start, fin;
    idx_t                  idle_idx, pre_idx, chosen;

    adc_arb_prio u_prio (
        .clk(clk), .rst_n(rst_n), .wr(prio_wr),
        .in_lp(prio_lp), .in_dg(prio_dg), .in_rf(prio_rf), .prio_q(prio)
    );

    assign busy = (state_q == ST_BUSY);

    // Per-client rejection and preemption terms.
    for (genvar g = 0; g < NREQ; g++) begin : g_cli
        assign frc_rej[g]  = req_start[g] && (mode == MODE_FORCE) && (int'(force_sel) != g);
        assign beat[g]     = arr[g] && busy && mode_is_fixed(mode) &&
                             (int'(owner_q) != g) && (prio[g] > prio[owner_q]);
        assign busy_rej[g] = busy && arr[g] && (int'(owner_q) != g) &&
                             !(pre_hit && (int'(pre_idx) == g));

        AST_PREEMPT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (done_q[g] && (word_q[g][WORD_W-1:DATA_W] == FLG_PREEMPT)) |->
            (word_q[g][DATA_W-1:0] == '0)); // R6
        AST_FLAG_CODE: assert property (@(posedge clk) disable iff (!rst_n)
            done_q[g] |-> (word_q[g][WORD_W-1:DATA_W] != 2'd3)); // R10
    end

    assign arr       = req_start & ~frc_rej;
    assign rej       = frc_rej | busy_rej;
    assign cand_idle = (state_q == ST_IDLE) ? (pend_q | arr) : '0;

    adc_arb_pick u_pick_idle (
        .cand(cand_idle), .mode(mode), .prio(prio), .ptr(ptr_q),
        .force_sel(force_sel), .hit(idle_hit), .idx(idle_idx)
    );

    adc_arb_pick u_pick_pre (
        .cand(beat), .mode(MODE_FIXED), .prio(prio), .ptr(ptr_q),
        .force_sel(force_sel), .hit(pre_hit), .idx(pre_idx)
    );

    adc_conv_stub #(.LAT(CONV_LAT)) u_conv (
        .clk(clk), .rst_n(rst_n), .start(start), .fin(fin)
    );

    // Start decision, chosen client and next waiting set.
    always_comb begin
        start      = idle_hit || pre_hit;
        chosen     = pre_hit ? pre_idx : idle_idx;
        sel_mask   = start ? (NREQ'(1) << chosen) : '0;
        pend_n     = (pend_q | (busy ? '0 : arr)) & ~rej & ~sel_mask;
        settle_eff = (int'(settle_cyc) > SETTLE_MAX) ? 3'(SETTLE_MAX) : settle_cyc;
    end

    // Ownership state machine and result word updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            owner_q <= '0;
            ptr_q   <= '0;
            scnt_q  <= '0;
            pend_q  <= '0;
            cs_q    <= 1'b0;
            done_q  <= '0;
            for (int i = 0; i < NREQ; i++) word_q[i] <= '0;
        end else begin
            cs_q   <= start;
            pend_q <= pend_n;
            done_q <= rej;
            for (int i = 0; i < NREQ; i++) begin
                if (rej[i]) word_q[i] <= {FLG_NOGRANT, {DATA_W{1'b0}}};
            end
            if (start) begin
                owner_q <= chosen;
                ptr_q   <= next_idx(chosen);
            end
            case (state_q)
                ST_IDLE: begin
                    if (idle_hit) state_q <= ST_BUSY;
                end
                ST_BUSY: begin
                    if (pre_hit) begin
                        done_q[owner_q] <= 1'b1;
                        word_q[owner_q] <= {FLG_PREEMPT, {DATA_W{1'b0}}};
                    end else if (fin) begin
                        done_q[owner_q] <= 1'b1;
                        word_q[owner_q] <= {FLG_OK, sample_in};
                        if (settle_eff == '0) begin
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_SETTLE;
                            scnt_q  <= settle_eff;
                        end
                    end
                end
                ST_SETTLE: begin
                    if (scnt_q <= 3'd1) state_q <= ST_IDLE;
                    else                scnt_q  <= scnt_q - 3'd1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign grant      = busy ? (NREQ'(1) << owner_q) : '0;
    assign conv_start = cs_q;
    assign res_done   = done_q;
    assign res_lp     = word_q[0];
    assign res_dg     = word_q[1];
    assign res_rf     = word_q[2];

    AST_START_HAS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $onehot(grant)); // R11
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R11
    AST_FORCE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && !$past(pre_hit) && ($past(mode) == MODE_FORCE)) |->
        (grant == (NREQ'(1) << $past(force_sel)))); // R5
endmodule

// File: tb/adc_share_arbiter_tb.sv
`timescale 1ns/1ps
module adc_share_arbiter_tb;
    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  req_start = '0;
    logic [1:0]  mode = '0;
    logic [1:0]  force_sel = '0;
    logic        prio_wr = 1'b0;
    logic [1:0]  prio_lp = '0, prio_dg = '0, prio_rf = '0;
    logic [2:0]  settle_cyc = '0;
    logic [12:0] sample_in = '0;
    logic [2:0]  grant, res_done;
    logic        conv_start;
    logic [14:0] res_lp, res_dg, res_rf;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    adc_share_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .mode(mode),
        .force_sel(force_sel), .prio_wr(prio_wr), .prio_lp(prio_lp),
        .prio_dg(prio_dg), .prio_rf(prio_rf), .settle_cyc(settle_cyc),
        .sample_in(sample_in), .grant(grant), .conv_start(conv_start),
        .res_done(res_done), .res_lp(res_lp), .res_dg(res_dg), .res_rf(res_rf)
    );

    // Behavioural reference model: 0 idle, 1 converting, 2 settling.
    int          m_state, m_own, m_cnt, m_scnt, m_ptr, win, pick;
    int          m_prio [3];
    bit          m_pend [3];
    bit          a [3];
    bit [2:0]    m_done;
    bit          m_cs;
    logic [14:0] m_word [3];
    int          np [3];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_own = 0; m_cnt = 0; m_scnt = 0; m_ptr = 0;
            m_prio[0] = 1; m_prio[1] = 0; m_prio[2] = 2;
            m_done = '0; m_cs = 0;
            for (int i = 0; i < 3; i++) begin m_pend[i] = 0; m_word[i] = '0; end
        end else begin
            m_cs = 0; m_done = '0;
            for (int i = 0; i < 3; i++) a[i] = req_start[i];
            for (int i = 0; i < 3; i++)
                if (a[i] && mode == 2 && int'(force_sel) != i) begin
                    m_done[i] = 1; m_word[i] = 15'h2000; a[i] = 0; m_pend[i] = 0;
                end
            if (m_state == 1) begin
                win = -1;
                for (int i = 0; i < 3; i++)
                    if (a[i] && mode != 1 && mode != 2 && i != m_own && m_prio[i] > m_prio[m_own] &&
                        (win < 0 || m_prio[i] > m_prio[win])) win = i;
                for (int i = 0; i < 3; i++)
                    if (a[i] && i != m_own && i != win) begin
                        m_done[i] = 1; m_word[i] = 15'h2000; m_pend[i] = 0;
                    end
                if (win >= 0) begin
                    m_done[m_own] = 1; m_word[m_own] = 15'h4000;
                    m_own = win; m_cnt = LAT-1; m_cs = 1; m_pend[win] = 0; m_ptr = (win+1)%3;
                end else if (m_cnt == 0) begin
                    m_done[m_own] = 1; m_word[m_own] = {2'b00, sample_in};
                    m_scnt = (settle_cyc > 4) ? 4 : int'(settle_cyc);
                    m_state = (m_scnt == 0) ? 0 : 2;
                end else m_cnt--;
            end else if (m_state == 2) begin
                for (int i = 0; i < 3; i++) m_pend[i] = m_pend[i] | a[i];
                if (m_scnt <= 1) m_state = 0; else m_scnt--;
            end else begin
                for (int i = 0; i < 3; i++) m_pend[i] = m_pend[i] | a[i];
                pick = -1;
                if (mode == 2) begin
                    if (force_sel < 3 && m_pend[force_sel]) pick = int'(force_sel);
                end else if (mode == 1) begin
                    for (int k = 0; k < 3; k++)
                        if (pick < 0 && m_pend[(m_ptr+k)%3]) pick = (m_ptr+k)%3;
                end else begin
                    for (int i = 0; i < 3; i++)
                        if (m_pend[i] && (pick < 0 || m_prio[i] > m_prio[pick])) pick = i;
                end
                if (pick >= 0) begin
                    m_pend[pick] = 0; m_state = 1; m_own = pick; m_cnt = LAT-1;
                    m_cs = 1; m_ptr = (pick+1)%3;
                end
            end
            np[0] = prio_lp; np[1] = prio_dg; np[2] = prio_rf;
            if (prio_wr && np[0] != np[1] && np[0] != np[2] && np[1] != np[2] &&
                np[0] <= 2 && np[1] <= 2 && np[2] <= 2)
                for (int i = 0; i < 3; i++) m_prio[i] = np[i];
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk(cur_req, "grant R11", int'(grant), (m_state == 1) ? (1 << m_own) : 0);
        chk(cur_req, "conv_start R11", int'(conv_start), int'(m_cs));
        chk(cur_req, "res_done R10", int'(res_done), int'(m_done));
        chk(cur_req, "res_lp R10", int'(res_lp), int'(m_word[0]));
        chk(cur_req, "res_dg R10", int'(res_dg), int'(m_word[1]));
        chk(cur_req, "res_rf R10", int'(res_rf), int'(m_word[2]));
    endtask

    task automatic cyc(input int n);
        for (int c = 0; c < n; c++) begin
            @(posedge clk);
            @(negedge clk);
            compare();
            req_start = '0;
            prio_wr = 1'b0;
        end
    endtask

    task automatic set_prio(input logic [1:0] lp, input logic [1:0] dg, input logic [1:0] rf);
        prio_wr = 1'b1; prio_lp = lp; prio_dg = dg; prio_rf = rf;
        cyc(1);
    endtask

    logic [15:0] lf = 16'hACE1;
    task automatic lf_step();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int gap;
        logic [2:0] prev_g;
        sample_in = 13'h1ABC;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: state right after reset
        chk("R1", "grant", int'(grant), 0);
        chk("R1", "conv_start", int'(conv_start), 0);
        chk("R1", "res_done", int'(res_done), 0);
        chk("R1", "res_lp", int'(res_lp), 0);

        // R6: radio preempts low-power conversion
        cur_req = "R6";
        req_start = 3'b001; cyc(1);
        chk("R1", "lp granted first", int'(grant), 1);
        cyc(1);
        req_start = 3'b100; cyc(1);
        chk("R6", "old owner done", int'(res_done), 1);
        chk("R6", "flag2 data0", int'(res_lp), 32'h4000);
        chk("R6", "new grant", int'(grant), 4);
        chk("R6", "restart pulse", int'(conv_start), 1);
        // R7: lower priority arrival rejected, owner restart ignored
        cur_req = "R7";
        req_start = 3'b001; cyc(1);
        chk("R7", "reject done", int'(res_done), 1);
        chk("R7", "flag1", int'(res_lp), 32'h2000);
        req_start = 3'b100; cyc(1);
        chk("R7", "owner restart ignored", int'(res_done), 0);
        chk("R7", "no new start", int'(conv_start), 0);
        cur_req = "R8";
        cyc(1);
        chk("R8", "not yet done", int'(res_done), 0);
        cyc(1);
        chk("R8", "done after latency", int'(res_done), 4);
        chk("R8", "valid data", int'(res_rf), 32'h1ABC);
        cyc(4);

        // R2 / R3: invalid then valid priority writes
        cur_req = "R2";
        set_prio(2'd2, 2'd2, 2'd0);
        req_start = 3'b111; cyc(1);
        chk("R2", "invalid write kept radio top", int'(grant), 4);
        cyc(30);
        cur_req = "R3";
        set_prio(2'd0, 2'd2, 2'd1);
        req_start = 3'b111; cyc(1);
        chk("R3", "digital highest", int'(grant), 2);
        cyc(30);
        set_prio(2'd1, 2'd0, 2'd2);

        // R5: forced mode
        cur_req = "R5";
        mode = 2'd2; force_sel = 2'd1; cyc(1);
        req_start = 3'b101; cyc(1);
        chk("R5", "non-selected rejected", int'(res_done), 5);
        chk("R5", "rf flag1", int'(res_rf), 32'h2000);
        req_start = 3'b010; cyc(1);
        chk("R5", "selected granted", int'(grant), 2);
        cyc(10);

        // R4: rotating mode alternation
        cur_req = "R4";
        mode = 2'd1; prev_g = '0;
        for (int c = 0; c < 40; c++) begin
            req_start = 3'b011; cyc(1);
            if (conv_start) begin
                if (prev_g != '0) chk("R4", "alternates", int'(grant != prev_g), 1);
                prev_g = grant;
            end
        end
        cyc(10);

        // R9: settle gap of four cycles
        cur_req = "R9";
        mode = 2'd0; settle_cyc = 3'd4;
        req_start = 3'b001;
        gap = 0;
        for (int c = 0; c < 20 && !res_done[0]; c++) cyc(1);
        req_start = 3'b001;
        for (int c = 0; c < 20 && gap == 0; c++) begin
            cyc(1);
            if (conv_start) gap = c + 1;
        end
        chk("R9", "settle gap", gap, 5);
        cyc(20);

        // Mixed stimulus in each mode, compared every cycle against the model
        for (int ph = 0; ph < 3; ph++) begin
            cur_req = (ph == 0) ? "R3" : (ph == 1) ? "R4" : "R5";
            mode = 2'(ph);
            for (int c = 0; c < 600; c++) begin
                lf_step();
                req_start = lf[2:0] & {3{lf[3] & lf[4]}};
                settle_cyc = lf[7:5];
                force_sel = lf[9:8];
                sample_in = {lf[12:0]};
                if (lf[15:12] == 4'h0) begin
                    prio_wr = 1'b1; prio_lp = lf[1:0]; prio_dg = lf[11:10]; prio_rf = lf[14:13];
                end
                cyc(1);
            end
        end
        req_start = '0;
        cyc(40);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule